// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

This block holds fourteen pulse-width-modulated DAC channels that a microcontroller programs over a byte-wide register bus. Each channel has its own 8-bit duty code. All channels share one period counter. A channel's output is high while the counter is below that channel's code. An RC network outside the chip turns the pulse train into an analog level.

Each output pin is open-drain. The block only reports when the pad must pull low, and a released pad reads high. A per-pin function bit chooses between the PWM waveform and a general-purpose port bit. One control bit picks the count rate. The block's clock runs at twice the base rate. In slow mode the counter advances on every second clock. In fast mode it advances on every clock. A second control bit picks a period of 253 or 256 counts. The period affects saturation: in the 253-count period, codes from FDh upward hold the output high. In the 256-count period, code FFh still gives one low count in every period.

A new duty code is copied into a per-channel working register only when a period ends, so a pulse is never cut short or lengthened partway through a period.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset, every duty register reads 00h, the control register reads 00h, and every pin follows its port bit.
- R2: The duty register of channel n is at address 20h+n and can be written and read back. Addresses that map to no register read 00h.
- R3: When the function bit of a pin is 0, `pad_pull_low` for that pin equals the inverse of its `port_bit`.
- R4: When the function bit is 1, `pad_pull_low` is 1 exactly while the PWM waveform is low. A high level is the released pad.
- R5: In the 256-count period (control bit 1 = 0), a code c from 01h to FEh gives c counts high in each period of 256 counts.
- R6: In the 256-count period, code FFh gives 255 counts high and one count low in every period.
- R7: In the 253-count period (control bit 1 = 1), the period is 253 counts. A code below FDh gives that many counts high. Codes FDh, FEh and FFh hold the output high without a break.
- R8: Code 00h holds the output low without a break in both period modes.
- R9: Control register 10h bit 0 selects the rate. At 1 the counter advances on every clock. At 0 it advances on every second clock, so one count lasts two clocks.
- R10: A duty code written partway through a period takes effect at the start of the next period.
- R11: Register 11h bits 7..0 are the function bits of channels 7..0, and register 12h bits 5..0 are those of channels 13..8. A 1 selects PWM and a 0 selects the port bit. Both registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the base PWM rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| port_bit | input | 14 | Port values for pins that are in port mode |
| pad_pull_low | output | 14 | 1 = pad pulls low, 0 = pad released |

## Verification
The assertions assume that the clock-rate and period bits change only while the counter is idle or between measurements. A switch from 256 to 253 counts while the count is above FCh would end that period early. The checks on the wrap and on the two-clock count rate also assume that reset lasts at least one clock. The stimulus writes the control register once per scenario and then waits two full periods before it samples any pin. It keeps every write apart from a measurement window, except in the deferred-update scenario, where the mid-period write is the point of the test.

// File: rtl/pwm_dac_pkg.sv
// Package: shared constants and the control-register layout for the PWM DAC bank.
// Assumes byte-wide register bus and 8-bit duty codes.
package pwm_dac_pkg;
    localparam int unsigned CODE_W = 8;

    // Decoded view of the control register (bit 1 = short period, bit 0 = fast count).
    typedef struct packed {
        logic short_period;
        logic fast_rate;
    } pwm_ctrl_t;
endpackage

// File: rtl/pwm_dac_regs.sv
// Module: register file of the PWM DAC bank.
// Holds one duty code per channel at BASE_ADDR+n, a control byte and
// the per-pin function bits packed into consecutive bytes at EN_ADDR.
// Assumes writes are single-cycle strobes; reads are combinational.
module pwm_dac_regs
    import pwm_dac_pkg::*;
#(
    parameter int unsigned NUM_CH    = 14,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h20,
    parameter logic [7:0]  CTRL_ADDR = 8'h10,
    parameter logic [7:0]  EN_ADDR   = 8'h11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [CODE_W-1:0]              bus_wdata,
    input  logic                           bus_we,
    output logic [CODE_W-1:0]              bus_rdata,
    output logic [NUM_CH-1:0][CODE_W-1:0]  duty,
    output logic [NUM_CH-1:0]              fn_pwm,
    output pwm_ctrl_t                      ctrl
);
    localparam int unsigned EN_BYTES = (NUM_CH + 7) / 8;
    localparam int unsigned EN_PAD   = EN_BYTES * 8;

    logic [EN_PAD-1:0] en_q;

    // Duty registers: one per channel, cleared by reset.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_duty
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty[n] <= '0;
            else if (bus_we && bus_addr == ADDR_W'(BASE_ADDR + n))
                duty[n] <= bus_wdata;
        end
    end

    // Function-bit bytes: bits past NUM_CH are held at zero.
    for (genvar b = 0; b < EN_BYTES; b++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[b*8 +: 8] <= '0;
            else if (bus_we && bus_addr == ADDR_W'(EN_ADDR + b))
                en_q[b*8 +: 8] <= bus_wdata;
        end
    end

    // Control register: rate and period select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (bus_we && bus_addr == ADDR_W'(CTRL_ADDR))
            ctrl <= pwm_ctrl_t'(bus_wdata[1:0]);
    end

    // Unused upper function bits read as zero.
    logic [EN_PAD-1:0] en_view;
    always_comb begin
        en_view = '0;
        en_view[NUM_CH-1:0] = en_q[NUM_CH-1:0];
    end
    assign fn_pwm = en_q[NUM_CH-1:0];

    // Read mux over all mapped addresses.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata = {6'b0, ctrl};
        for (int n = 0; n < NUM_CH; n++)
            if (bus_addr == ADDR_W'(BASE_ADDR + n))
                bus_rdata = duty[n];
        for (int b = 0; b < EN_BYTES; b++)
            if (bus_addr == ADDR_W'(EN_ADDR + b))
                bus_rdata = en_view[b*8 +: 8];
    end
endmodule

// File: rtl/pwm_dac_timebase.sv
// Module: shared period counter of the PWM DAC bank.
// Produces a count enable (every clock in fast mode, every second clock
// otherwise) and a counter that wraps after SHORT_LEN or LONG_LEN counts.
// Assumes LONG_LEN is a power of two no larger than 2**CNT_W.
module pwm_dac_timebase
    import pwm_dac_pkg::*;
#(
    parameter int unsigned LONG_LEN  = 256,
    parameter int unsigned SHORT_LEN = 253,
    parameter int unsigned CNT_W     = $clog2(LONG_LEN),
    parameter int unsigned LEN_W     = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_ctrl_t        ctrl,
    output logic             tick,
    output logic             period_start,
    output logic [CNT_W-1:0] cnt,
    output logic [LEN_W-1:0] period_len
);
    logic phase;

    assign period_len   = ctrl.short_period ? LEN_W'(SHORT_LEN) : LEN_W'(LONG_LEN);
    assign tick         = ctrl.fast_rate | phase;
    assign period_start = tick && ({1'b0, cnt} >= period_len - LEN_W'(1));

    // Half-rate phase toggle used when the slow rate is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Period counter: advances on tick, wraps at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (period_start) cnt <= '0;
        else if (tick)         cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/pwm_dac_channel.sv
// Module: one PWM DAC channel with its pin mux.
// Latches the saturated duty code at each period start, compares it with
// the shared counter and chooses between the PWM level and a port bit.
// Output is open-drain style: pull_low = 1 drives the pad low.
module pwm_dac_channel
    import pwm_dac_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LEN_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LEN_W-1:0]  period_len,
    input  logic [CODE_W-1:0] duty,
    input  logic              fn_pwm,
    input  logic              port_bit,
    output logic              pull_low
);
    logic [LEN_W-1:0] sat_code;
    logic [LEN_W-1:0] work_code;
    logic             pwm_high;

    // Clamp the code to the period length.
    always_comb begin
        sat_code = LEN_W'(duty);
        if (sat_code > period_len) sat_code = period_len;
    end

    // Working code: updated only when a period ends.
    always_ff @(posedge clk) begin
        if (!rst_n)            work_code <= '0;
        else if (period_start) work_code <= sat_code;
    end

    assign pwm_high = {1'b0, cnt} < work_code;
    assign pull_low = fn_pwm ? ~pwm_high : ~port_bit;
endmodule

// File: rtl/pwm_dac_bank.sv
// Module: top of the PWM DAC bank.
// Ties the register file, the shared timebase and NUM_CH channel slices.
// Assumes a single clock at twice the base PWM rate and synchronous reset.
module pwm_dac_bank
    import pwm_dac_pkg::*;
#(
    parameter int unsigned NUM_CH    = 14,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned LONG_LEN  = 256,
    parameter int unsigned SHORT_LEN = 253,
    parameter logic [7:0]  BASE_ADDR = 8'h20,
    parameter logic [7:0]  CTRL_ADDR = 8'h10,
    parameter logic [7:0]  EN_ADDR   = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] port_bit,
    output logic [NUM_CH-1:0] pad_pull_low
);
    localparam int unsigned CNT_W = $clog2(LONG_LEN);
    localparam int unsigned LEN_W = CNT_W + 1;

    logic [NUM_CH-1:0][CODE_W-1:0] duty;
    logic [NUM_CH-1:0]             fn_pwm;
    pwm_ctrl_t                     ctrl;
    logic                          ctrl_fast;
    logic                          ctrl_short;
    logic                          tick;
    logic                          period_start;
    logic [CNT_W-1:0]              cnt;
    logic [LEN_W-1:0]              period_len;

    assign ctrl_fast  = ctrl.fast_rate;
    assign ctrl_short = ctrl.short_period;

    pwm_dac_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .EN_ADDR(EN_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .duty(duty), .fn_pwm(fn_pwm),
        .ctrl(ctrl)
    );

    pwm_dac_timebase #(
        .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick(tick),
        .period_start(period_start), .cnt(cnt), .period_len(period_len)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_dac_channel #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .period_start(period_start), .cnt(cnt),
            .period_len(period_len), .duty(duty[n]), .fn_pwm(fn_pwm[n]),
            .port_bit(port_bit[n]), .pull_low(pad_pull_low[n])
        );
    end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
// Checker: timing properties of the PWM DAC bank, bound to the top module.
module pwm_dac_bank_chk #(
    parameter int unsigned NUM_CH = 14,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_fast,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] fn_pwm,
    input logic [NUM_CH-1:0] port_bit,
    input logic [NUM_CH-1:0] pad_pull_low
);
    // R9: the counter holds between count enables.
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R9: fast rate enables counting on every clock.
    assert_fast_every_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_fast |-> tick);

    // R9: slow rate never counts on two clocks in a row.
    assert_slow_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_fast) |=> !(tick && !ctrl_fast));

    // R5: the top count always wraps to zero.
    assert_wrap_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == {CNT_W{1'b1}}) |=> cnt == '0);

    // R3: a pin in port mode follows the inverted port bit.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_port
        assert_port_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !fn_pwm[n] |-> pad_pull_low[n] == !port_bit[n]);
    end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_fast(ctrl_fast), .tick(tick), .cnt(cnt),
    .fn_pwm(fn_pwm), .port_bit(port_bit), .pad_pull_low(pad_pull_low)
);

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;
    localparam int NCH = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] port_bit = '0;
    logic [NCH-1:0] pad_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_dac_bank u_pwm_dac_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .port_bit(port_bit),
        .pad_pull_low(pad_pull_low)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Count released (high) clocks of a channel over a window of clocks.
    task automatic high_clocks(input int ch, input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (!pad_pull_low[ch]) hi++;
        end
    endtask

    // Program a code, settle two periods, then measure one period.
    task automatic pwm_case(input string req, input int ch, input int code,
                            input int fast, input int shrt);
        int per, div, hi, expc;
        per  = shrt ? 253 : 256;
        div  = fast ? 1 : 2;
        expc = (code > per) ? per : code;
        wr(8'h10, 8'(shrt * 2 + fast));
        wr(8'(8'h20 + ch), 8'(code));
        repeat (2 * per * div + 4) @(negedge clk);
        high_clocks(ch, per * div, hi);
        check(req, hi, expc * div);
    endtask

    task automatic t_reset;
        int v;
        for (int n = 0; n < NCH; n++) begin
            rd(8'(8'h20 + n), v);
            check("R1 duty reset", v, 0);
        end
        rd(8'h10, v);
        check("R1 ctrl reset", v, 0);
        port_bit = 14'h2A5C;
        @(negedge clk);
        check("R1 pins follow port", int'(pad_pull_low), int'(~14'h2A5C & 14'h3FFF));
    endtask

    task automatic t_regs;
        int v;
        wr(8'h20, 8'hA5); wr(8'h2D, 8'h3C);
        rd(8'h20, v); check("R2 ch0 readback", v, 8'hA5);
        rd(8'h2D, v); check("R2 ch13 readback", v, 8'h3C);
        rd(8'h05, v); check("R2 unmapped", v, 0);
        rd(8'h2E, v); check("R2 past last channel", v, 0);
        wr(8'h11, 8'h81); wr(8'h12, 8'h20);
        rd(8'h11, v); check("R11 enable low byte", v, 8'h81);
        rd(8'h12, v); check("R11 enable high byte", v, 8'h20);
        wr(8'h20, 8'h00); wr(8'h2D, 8'h00);
    endtask

    task automatic t_port;
        // channels 0, 7, 13 in PWM with code 0 -> pulled low; others follow port.
        repeat (1100) @(negedge clk);
        port_bit = 14'h3FFF;
        @(negedge clk);
        check("R3 port high released", int'(pad_pull_low), 14'h2081);
        port_bit = 14'h0000;
        @(negedge clk);
        check("R3 port low pulled", int'(pad_pull_low), 14'h3FFF);
        wr(8'h11, 8'h00); wr(8'h12, 8'h00);
        port_bit = 14'h1555;
        @(negedge clk);
        check("R11 disabled follows port", int'(pad_pull_low), int'(~14'h1555 & 14'h3FFF));
    endtask

    task automatic t_pwm;
        int hi;
        wr(8'h11, 8'h1F); wr(8'h12, 8'h20);
        port_bit = '0;
        pwm_case("R5 slow 256 code 64", 1, 64, 0, 0);
        pwm_case("R5 fast 256 code 200", 2, 200, 1, 0);
        pwm_case("R6 256 code FF", 3, 255, 1, 0);
        pwm_case("R7 253 code 200", 4, 200, 1, 1);
        pwm_case("R7 253 code FD", 1, 253, 0, 1);
        pwm_case("R7 253 code FE", 2, 254, 1, 1);
        pwm_case("R7 253 code FF", 3, 255, 1, 1);
        pwm_case("R8 256 code 00", 4, 0, 1, 0);
        pwm_case("R8 253 code 00", 4, 0, 0, 1);
        pwm_case("R9 slow 256 code 1", 13, 1, 0, 0);
        pwm_case("R4 fast 253 code 100", 0, 100, 1, 1);
    endtask

    task automatic t_deferred;
        int cnt_hi;
        logic prev;
        wr(8'h10, 8'h00);
        wr(8'h22, 8'd100);
        repeat (1100) @(negedge clk);
        // wait for the start of a high pulse
        prev = pad_pull_low[2];
        forever begin
            @(negedge clk);
            if (prev && !pad_pull_low[2]) break;
            prev = pad_pull_low[2];
        end
        bus_addr = 8'h22; bus_wdata = 8'd30; bus_we = 1'b1;
        cnt_hi = 1;
        @(negedge clk);
        bus_we = 1'b0;
        while (!pad_pull_low[2]) begin
            cnt_hi++;
            @(negedge clk);
        end
        check("R10 old code holds this period", cnt_hi, 200);
        while (pad_pull_low[2]) @(negedge clk);
        cnt_hi = 0;
        while (!pad_pull_low[2]) begin
            cnt_hi++;
            @(negedge clk);
        end
        check("R10 new code next period", cnt_hi, 60);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_port;
        t_pwm;
        t_deferred;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule